// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer with Acknowledged Writes

This peripheral sits on a plain 32-bit register bus made of a byte address, a write strobe, write data and read data. A global setting picks the tick rate. An 8-bit prescale value divides the input clock by (value + 1). A 3-bit select then divides the result by a power of two. One countdown channel counts those ticks. Software loads a tick count, starts the channel, and receives an expired flag when the count runs out. That flag can be gated onto a single interrupt line.

Writes to the count register and the run/stop register do not act at once. They wait through a synchronisation delay of two ticks. When a write finally takes effect, the block raises a sticky acknowledge bit, and software clears that bit by writing 1 to it. The expected driver sequence for a one-shot run has three steps: halt the channel, load the count, then set the run bit. Before each next step, the driver polls the acknowledge bit of the previous write.

Top module: `cdt_timer`

## Requirements
- R1: After reset, every mapped register reads zero, the channel is halted and `irq_o` is low.
- R2: The configuration word at offset 0x000 holds the prescale value in bits [7:0] and the divider select in bits [10:8], and reads back as written. Ticks fall every (prescale+1)*2^select clock edges, counted from the edge that accepted the configuration write, which restarts the divider phase.
- R3: A write of N to offset 0x310 loads the countdown with N. Reading 0x310 returns the live count.
- R4: Bit 3 of offset 0x320 is the run bit: 1 starts the countdown and 0 halts it. Reads return the run state actually in effect, and hardware clears that state when the count expires.
- R5: A write to 0x310 or 0x320 takes effect at the second tick edge strictly after the edge that accepted it. At that same edge, acknowledge bit 2 (count write) or bit 3 (run write) of offset 0x340 sets. Before that edge, the old count and run state still apply.
- R6: The acknowledge bits stay set until a write to 0x340 carries 1 in the bit position. A 0 in that position leaves the bit unchanged.
- R7: While running, the count drops by one on each tick. On the Nth tick after the run bit takes effect (the first tick when N is 0 or 1), the count reads 0, bit 1 of offset 0x330 sets and the channel halts.
- R8: Writing 1 to bit 1 of 0x330 clears the expired flag. The flag does not set again until the channel is reloaded and restarted.
- R9: `irq_o` is a register equal to the expired flag AND bit 1 of offset 0x334, one clock edge later. It stays low while that enable bit is 0.
- R10: Read data is registered and appears one clock edge after the address. Unmapped offsets read zero, and writes to them change nothing.
- R11: Halting the channel freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Expired interrupt, gated by the enable bit |

## Verification
A divider stuck at the wrong phase or ratio moves the interrupt edge by whole tick periods. That error shows on `irq_o` at the end of the very first countdown, so the bench predicts the exact rising edge from the configuration write, the run write and the tick period. A pending write that commits one tick early or late shows in two places: it shifts that same edge, and it changes the acknowledge bit, which reads back on the next bus read. A count or run state that drifts while halted shows as two unequal reads of the live count taken a few dozen cycles apart.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int PRESC_W    = 8;
  localparam int SEL_W      = 3;
  localparam int SYNC_TICKS = 2;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_LOAD = 12'h310;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h320;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h330;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 12'h334;
  localparam logic [ADDR_W-1:0] OFF_WACK = 12'h340;

  localparam int BIT_RUN      = 3;
  localparam int BIT_EXP      = 1;
  localparam int BIT_IEN      = 1;
  localparam int BIT_ACK_LOAD = 2;
  localparam int BIT_ACK_CTRL = 3;
endpackage

// File: rtl/cdt_tick_gen.sv
module cdt_tick_gen #(
  parameter int PRESC_W = 8,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [PRESC_W-1:0] pre_q;
  logic [DIV_W-1:0]   div_q;
  logic [DIV_W-1:0]   mask;
  logic               pre_hit;

  // low 'sel' bits of the stage counter must all be one for a tick
  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel_i));
  end

  assign pre_hit = (pre_q == presc_i);
  assign tick_o  = pre_hit && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_hit) begin
      pre_q <= '0;
      div_q <= div_q + DIV_W'(1);
    end else begin
      pre_q <= pre_q + PRESC_W'(1);
    end
  end

  // R2: with a prescale above zero, ticks are never on adjacent edges
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !restart_i && presc_i != '0) |=> !tick_o);
endmodule

// File: rtl/cdt_wr_sync.sv
module cdt_wr_sync #(
  parameter int W          = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         tick_i,
  output logic         commit_o,
  output logic [W-1:0] data_o
);
  localparam int STG_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

  logic             pend_q;
  logic [STG_W-1:0] stg_q;
  logic             last;

  assign last     = (stg_q == STG_W'(SYNC_TICKS - 1));
  assign commit_o = pend_q && tick_i && last && !wr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      stg_q  <= '0;
      data_o <= '0;
    end else if (wr_i) begin
      pend_q <= 1'b1;
      stg_q  <= '0;
      data_o <= data_i;
    end else if (pend_q && tick_i) begin
      if (last) pend_q <= 1'b0;
      else      stg_q  <= stg_q + STG_W'(1);
    end
  end

  generate
    if (SYNC_TICKS > 1) begin : g_early
      // R5: a fresh write never commits in the cycle it becomes pending
      a_r5_no_early_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> !commit_o);
    end
  endgenerate
endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_wr_i,
  input  logic             run_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             at_end;
  logic             step;

  assign at_end    = (cnt_q <= CNT_W'(1));
  assign step      = tick_i && run_q && !run_wr_i;
  assign expire_o  = step && at_end;
  assign count_o   = cnt_q;
  assign running_o = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (run_wr_i)      run_q <= run_val_i;
      else if (expire_o) run_q <= 1'b0;

      if (load_i)        cnt_q <= load_val_i;
      else if (expire_o) cnt_q <= '0;
      else if (step)     cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R11: halted and not reloaded means the count holds
  a_r11_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load_i) |=> $stable(cnt_q));
  // R7: one decrement per tick while running
  a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load_i && !at_end) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R7: expiry leaves the channel halted
  a_r7_halt_on_expire: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !run_q);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int ADDR_W = cdt_pkg::ADDR_W,
  parameter int DATA_W = cdt_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import cdt_pkg::*;

  localparam int CFG_W = PRESC_W + SEL_W;

  logic [CFG_W-1:0]  cfg_q;
  logic              ien_q;
  logic              exp_q;
  logic [1:0]        ack_q;   // [0] count write, [1] run write
  logic              tick;
  logic              wr_cfg, wr_load, wr_ctrl, wr_stat, wr_ien, wr_wack;
  logic [1:0]        commit;
  logic [DATA_W-1:0] load_val;
  logic [0:0]        run_val;
  logic [DATA_W-1:0] count;
  logic              running;
  logic              expire;
  logic [DATA_W-1:0] rd_next;

  assign wr_cfg  = bus_we && (bus_addr == ADDR_W'(OFF_CFG));
  assign wr_load = bus_we && (bus_addr == ADDR_W'(OFF_LOAD));
  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_ien  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_wack = bus_we && (bus_addr == ADDR_W'(OFF_WACK));

  cdt_tick_gen #(.PRESC_W(PRESC_W), .SEL_W(SEL_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart_i(wr_cfg),
    .presc_i  (cfg_q[PRESC_W-1:0]),
    .sel_i    (cfg_q[CFG_W-1:PRESC_W]),
    .tick_o   (tick)
  );

  cdt_wr_sync #(.W(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_sync_load (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_load),
    .data_i  (bus_wdata),
    .tick_i  (tick),
    .commit_o(commit[0]),
    .data_o  (load_val)
  );

  cdt_wr_sync #(.W(1), .SYNC_TICKS(SYNC_TICKS)) u_sync_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_ctrl),
    .data_i  (bus_wdata[BIT_RUN:BIT_RUN]),
    .tick_i  (tick),
    .commit_o(commit[1]),
    .data_o  (run_val)
  );

  cdt_countdown #(.CNT_W(DATA_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .load_i    (commit[0]),
    .load_val_i(load_val),
    .run_wr_i  (commit[1]),
    .run_val_i (run_val[0]),
    .count_o   (count),
    .running_o (running),
    .expire_o  (expire)
  );

  localparam int ACK_POS [2] = '{BIT_ACK_LOAD, BIT_ACK_CTRL};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_ack
      always_ff @(posedge clk) begin
        if (rst)                                     ack_q[g] <= 1'b0;
        else if (commit[g])                          ack_q[g] <= 1'b1;
        else if (wr_wack && bus_wdata[ACK_POS[g]])   ack_q[g] <= 1'b0;
      end
      // R6: only a write of 1 drops an acknowledge bit
      a_r6_ack_sticky: assert property (@(posedge clk) disable iff (rst)
        (ack_q[g] && !(wr_wack && bus_wdata[ACK_POS[g]])) |=> ack_q[g]);
      // R5: an acknowledge appears only at a tick edge
      a_r5_ack_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q[g]) |-> $past(tick));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ien_q <= 1'b0;
      exp_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata[CFG_W-1:0];
      if (wr_ien) ien_q <= bus_wdata[BIT_IEN];
      if (expire)                          exp_q <= 1'b1;
      else if (wr_stat && bus_wdata[BIT_EXP]) exp_q <= 1'b0;
      irq_o <= exp_q && ien_q;
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      ADDR_W'(OFF_CFG):  rd_next[CFG_W-1:0]  = cfg_q;
      ADDR_W'(OFF_LOAD): rd_next             = count;
      ADDR_W'(OFF_CTRL): rd_next[BIT_RUN]    = running;
      ADDR_W'(OFF_STAT): rd_next[BIT_EXP]    = exp_q;
      ADDR_W'(OFF_IEN):  rd_next[BIT_IEN]    = ien_q;
      ADDR_W'(OFF_WACK): begin
        rd_next[BIT_ACK_LOAD] = ack_q[0];
        rd_next[BIT_ACK_CTRL] = ack_q[1];
      end
      default:           rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R9: interrupt needs the enable bit one edge earlier
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ien_q));
  // R8: the expired flag sets only at a tick edge
  a_r8_exp_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(exp_q) |-> $past(tick));
endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int last_edge = 0;

  localparam logic [11:0] A_CFG = 12'h000, A_LOAD = 12'h310, A_CTRL = 12'h320,
                          A_STAT = 12'h330, A_IEN = 12'h334, A_WACK = 12'h340;

  // {prescale, select, count}
  localparam logic [47:0] VEC [5] = '{
    {8'd0, 8'd0, 32'd5},
    {8'd2, 8'd0, 32'd3},
    {8'd1, 8'd2, 32'd4},
    {8'd0, 8'd3, 32'd1},
    {8'd3, 8'd1, 32'd0}
  };

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdt_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    last_edge = cyc;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_ack(input int b, input bit clr);
    logic [31:0] v;
    for (int k = 0; k < 4000; k++) begin
      rd(A_WACK, v);
      if (v[b]) break;
    end
    check(v[b] == 1'b1, "R5 ack", {31'b0, v[b]}, 1);
    if (clr) wr(A_WACK, 32'(1) << b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    foreach (VEC[i]) begin end
    rd(A_CFG, v);  check(v == 0, "R1 cfg", v, 0);
    rd(A_LOAD, v); check(v == 0, "R1 count", v, 0);
    rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    rd(A_STAT, v); check(v == 0, "R1 stat", v, 0);
    rd(A_IEN, v);  check(v == 0, "R1 ien", v, 0);
    rd(A_WACK, v); check(v == 0, "R1 wack", v, 0);
    check(irq_o == 1'b0, "R1 irq", {31'b0, irq_o}, 0);

    // R10 unmapped offsets
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, v); check(v == 0, "R10 unmapped", v, 0);
    rd(12'h344, v); check(v == 0, "R10 unmapped", v, 0);

    // vector table: exact interrupt edge, R2 R3 R4 R7 R8 R9
    for (int i = 0; i < 5; i++) begin
      int p, s, n, per, ec, ew, sc, exp_edge, rise;
      p = int'(VEC[i][47:40]); s = int'(VEC[i][34:32]); n = int'(VEC[i][31:0]);
      per = (p + 1) << s;
      wr(A_CFG, {21'b0, 3'(s), 8'(p)}); ec = last_edge;
      rd(A_CFG, v); check(v == {21'b0, 3'(s), 8'(p)}, "R2 cfg readback", v, {21'b0, 3'(s), 8'(p)});
      wr(A_IEN, 32'h2);
      wr(A_CTRL, 32'h0); wait_ack(3, 1'b1);
      wr(A_LOAD, 32'(n)); wait_ack(2, 1'b1);
      rd(A_LOAD, v); check(v == 32'(n), "R3 load", v, 32'(n));
      wr(A_CTRL, 32'h8); ew = last_edge;
      sc = ec + (((ew - ec) / per) + 2) * per;
      exp_edge = sc + ((n < 1) ? 1 : n) * per + 1;
      rise = -1;
      for (int k = 0; k < 5000; k++) begin
        @(negedge clk);
        if (irq_o) begin rise = cyc; break; end
      end
      check(rise == exp_edge, "R2 R5 R7 irq edge", 32'(rise), 32'(exp_edge));
      wait_ack(3, 1'b1);
      rd(A_CTRL, v); check(v == 0, "R4 run cleared", v, 0);
      rd(A_LOAD, v); check(v == 0, "R7 count zero", v, 0);
      rd(A_STAT, v); check(v == 32'h2, "R7 expired", v, 2);
      wr(A_STAT, 32'h2); idle(1);
      check(irq_o == 1'b0, "R8 R9 irq cleared", {31'b0, irq_o}, 0);
    end

    // R5: no effect before the second tick
    wr(A_CFG, {21'b0, 3'd0, 8'd10});
    wr(A_LOAD, 32'd77);
    rd(A_WACK, v); check(v == 0, "R5 no early ack", v, 0);
    rd(A_LOAD, v); check(v == 0, "R5 old count", v, 0);
    wait_ack(2, 1'b0);
    rd(A_LOAD, v); check(v == 77, "R5 count after ack", v, 77);

    // R6 sticky acknowledge
    idle(20);
    rd(A_WACK, v); check(v == 32'h4, "R6 still set", v, 4);
    wr(A_WACK, 32'h0);
    rd(A_WACK, v); check(v == 32'h4, "R6 zero write", v, 4);
    wr(A_WACK, 32'h4);
    rd(A_WACK, v); check(v == 0, "R6 cleared", v, 0);

    // R11 halt freezes count
    wr(A_LOAD, 32'd1000); wait_ack(2, 1'b1);
    wr(A_CTRL, 32'h8); wait_ack(3, 1'b1);
    rd(A_CTRL, v); check(v == 32'h8, "R4 running", v, 8);
    idle(200);
    wr(A_CTRL, 32'h0); wait_ack(3, 1'b1);
    rd(A_LOAD, c1); idle(50); rd(A_LOAD, c2);
    check(c1 == c2, "R11 frozen", c2, c1);
    check(c1 < 1000 && c1 > 0, "R7 counted down", c1, 1000);

    // R9 enable low keeps irq low
    wr(A_IEN, 32'h0);
    wr(A_LOAD, 32'd2); wait_ack(2, 1'b1);
    wr(A_CTRL, 32'h8); wait_ack(3, 1'b1);
    idle(200);
    check(irq_o == 1'b0, "R9 gated off", {31'b0, irq_o}, 0);
    rd(A_STAT, v); check(v == 32'h2, "R7 expired gated", v, 2);
    wr(A_IEN, 32'h2); idle(1);
    check(irq_o == 1'b1, "R9 enable raises irq", {31'b0, irq_o}, 1);
    wr(A_STAT, 32'h2);

    // R8 no second expiry
    idle(100);
    rd(A_STAT, v); check(v == 0, "R8 stays clear", v, 0);
    check(irq_o == 1'b0, "R8 irq low", {31'b0, irq_o}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule